// File: doc/BRIEF.md
# MSK Delay-Detection Demodulator with Bit-Clock Recovery

This block turns a one-bit, already-sliced minimum-shift-keyed subcarrier (nominally 76 kHz) into a recovered data stream and a bit-rate strobe. It samples the input on the 7.2 MHz system clock. Each sample is compared with copies of the signal delayed by one bit period (1T) and by two bit periods (2T). Both delays are plain shift registers of `BIT_CYC` stages each. The 1T comparison, integrated over a recovered bit window, gives the raw bit decision. The 2T comparison gives a parity check that lets the block correct an isolated wrong 1T decision.

A digital PLL keeps a phase counter that runs over `BIT_CYC` system cycles, with 450 cycles at 16 kbit/s. It moves the phase by one cycle at each transition of the 1T comparison. Transitions seen in the first half of the window lengthen the bit and those seen in the second half shorten it. At each window wrap the block emits a one-cycle strobe together with the corrected bit. Two monitor outputs bring out the recovered bit clock and the last decided bit. Downstream framing logic consumes `data_o` whenever `bit_stb_o` is high.

Top module: `msk_dd_demod`

## Requirements
- R1: While `rst_ni` is low, `data_o`, `bit_stb_o` and `data_mon_o` are 0 and `clk_mon_o` is 1. The delay lines, the integrators and the phase counter all clear to zero.
- R2: With no transition of the 1T comparison, `bit_stb_o` pulses for exactly one cycle every `BIT_CYC` cycles.
- R3: At each strobe, `data_o` carries the decision for the bit window before the one just closed: 1 means the input differed from its 1T-delayed copy, 0 means it matched. Outside strobes `data_o` is 0.
- R4: A window decides "differs" only when the count of differing samples is strictly greater than half of `BIT_CYC`. A minority of disturbed samples (200 of 450) leaves the decision unchanged.
- R5: When the 2T comparison disagrees with the XOR of two consecutive 1T decisions in both parity checks that cover a bit, that bit is inverted before output. No two consecutive bits are ever both corrected.
- R6: A 1T-comparison transition at phase 1 to `BIT_CYC`/2-1 stretches the current bit window by one cycle. A transition at phase `BIT_CYC`/2 or later shortens it by one cycle. A transition at phase 0 leaves the window unchanged.
- R7: While `standby_i` is high, no strobe is produced and all state holds. After release, the bit stream continues as if the pause had not happened.
- R8: `clk_mon_o` is high while the phase counter is below `BIT_CYC`/2 and low otherwise. `data_mon_o` holds the bit last given on `data_o` and changes only with a strobe.
- R9: Changes of `msk_i` while `standby_i` is high have no effect on the recovered stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 7.2 MHz system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | High freezes all state and suppresses strobes |
| msk_i | input | 1 | Sliced MSK subcarrier, asynchronous |
| data_o | output | 1 | Corrected bit, valid while bit_stb_o is high |
| bit_stb_o | output | 1 | One-cycle strobe per recovered bit |
| data_mon_o | output | 1 | Last recovered bit, held between strobes |
| clk_mon_o | output | 1 | Recovered bit clock, high in the first half of the bit |

## Verification
The bench drives a pseudo-random level stream and checks each strobe against bit differences computed from that stream. Inside the stream it inverts a 270-cycle stretch that straddles a bit boundary. This flips only one 1T window and no 2T window. A design without 2T correction would output one wrong bit there, and a design with a loose majority threshold would corrupt the neighbouring bits. With a held input, the bench places single transitions early and late in a window and measures the strobe spacing. An inverted phase nudge would show up as 449 instead of 451 cycles or the reverse. A standby pause with input toggling inside it must leave the stream intact. A design that kept sampling during standby would shift or flip bits after the pause.

// File: rtl/msk_dd_pkg.sv
package msk_dd_pkg;
  localparam int unsigned NUM_TAPS = 2;

  typedef struct packed {
    logic diff_1t;
    logic diff_2t;
  } det_t;
endpackage

// File: rtl/msk_dd_delay_line.sv
module msk_dd_delay_line #(
  parameter int unsigned DEPTH = 450
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sr_q <= '0;
    else if (en_i) sr_q <= {sr_q[DEPTH-2:0], d_i};
  end

  assign q_o = sr_q[DEPTH-1];
endmodule

// File: rtl/msk_dd_dpll.sv
module msk_dd_dpll #(
  parameter int unsigned BIT_CYC = 450
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cmp_i,
  output logic wrap_o,
  output logic clk_mon_o
);
  localparam int unsigned PW   = $clog2(BIT_CYC + 2);
  localparam int unsigned HALF = BIT_CYC / 2;

  logic [PW-1:0] phase_q, phase_sum, step;
  logic          cmp_q, edge_det, wrap;

  always_comb begin
    edge_det = cmp_i ^ cmp_q;
    step     = PW'(1);
    if (edge_det && (phase_q != '0))
      step = (phase_q < PW'(HALF)) ? PW'(0) : PW'(2);
    phase_sum = phase_q + step;
    wrap      = (phase_sum >= PW'(BIT_CYC));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      cmp_q   <= 1'b0;
    end else if (en_i) begin
      cmp_q   <= cmp_i;
      phase_q <= wrap ? (phase_sum - PW'(BIT_CYC)) : phase_sum;
    end
  end

  assign wrap_o    = wrap & en_i;
  assign clk_mon_o = (phase_q < PW'(HALF));

  // window length monitor
  logic [PW:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gap_q <= '0;
    else if (en_i) begin
      if (wrap)              gap_q <= '0;
      else if (gap_q != '1)  gap_q <= gap_q + 1'b1;
    end
  end

  p_phase_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q < PW'(BIT_CYC));

  p_window_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> (gap_q >= (PW+1)'(HALF)));

  p_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(phase_q));
endmodule

// File: rtl/msk_dd_detector.sv
module msk_dd_detector
  import msk_dd_pkg::*;
#(
  parameter int unsigned BIT_CYC = 450
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                wrap_i,
  input  logic                s_i,
  input  logic [NUM_TAPS-1:0] taps_i,
  output det_t                det_o
);
  localparam int unsigned CW      = $clog2(2 * BIT_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(2 * BIT_CYC);
  localparam logic [CW:0]   THR     = (CW+1)'(BIT_CYC);

  logic [NUM_TAPS-1:0] dec;

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_path
    logic          cmp;
    logic [CW-1:0] cnt_q, tot;

    assign cmp    = s_i ^ taps_i[i];
    assign tot    = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CW'(cmp);
    // strict majority over the closing window, current sample included
    assign dec[i] = ({tot, 1'b0} > THR);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   cnt_q <= '0;
      else if (en_i) cnt_q <= wrap_i ? '0 : tot;
    end
  end

  assign det_o.diff_1t = dec[0];
  assign det_o.diff_2t = dec[1];
endmodule

// File: rtl/msk_dd_corrector.sv
module msk_dd_corrector
  import msk_dd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  det_t det_i,
  output logic bit_o
);
  logic e1_m1_q, e1_m2_q, e2_m1_q, last_fix_q;
  logic syn_a, syn_b, fix;

  // 2T decision should equal XOR of the two 1T decisions it spans
  assign syn_a = e2_m1_q ^ e1_m1_q ^ e1_m2_q;
  assign syn_b = det_i.diff_2t ^ det_i.diff_1t ^ e1_m1_q;
  assign fix   = syn_a & syn_b;
  assign bit_o = e1_m1_q ^ fix;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e1_m1_q    <= 1'b0;
      e1_m2_q    <= 1'b0;
      e2_m1_q    <= 1'b0;
      last_fix_q <= 1'b0;
    end else if (wrap_i) begin
      e1_m2_q    <= bit_o;
      e1_m1_q    <= det_i.diff_1t;
      e2_m1_q    <= det_i.diff_2t;
      last_fix_q <= fix;
    end
  end

  p_no_back_to_back_fix_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && last_fix_q) |-> !fix);
endmodule

// File: rtl/msk_dd_demod.sv
module msk_dd_demod
  import msk_dd_pkg::*;
#(
  parameter int unsigned BIT_CYC     = 450,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic standby_i,
  input  logic msk_i,
  output logic data_o,
  output logic bit_stb_o,
  output logic data_mon_o,
  output logic clk_mon_o
);
  logic                   en;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   s;
  logic [NUM_TAPS:0]      chain;
  logic                   cmp_1t, wrap, corr;
  det_t                   det;
  logic                   data_q, stb_q, mon_q;

  assign en = ~standby_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  sync_q <= '0;
    else if (en)  sync_q <= {sync_q[SYNC_STAGES-2:0], msk_i};
  end
  assign s = sync_q[SYNC_STAGES-1];

  // chain[1] = 1T copy, chain[2] = 2T copy
  assign chain[0] = s;
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    msk_dd_delay_line #(.DEPTH(BIT_CYC)) u_dly (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en),
      .d_i    (chain[i]),
      .q_o    (chain[i+1])
    );
  end

  assign cmp_1t = s ^ chain[1];

  msk_dd_dpll #(.BIT_CYC(BIT_CYC)) u_dpll (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .cmp_i     (cmp_1t),
    .wrap_o    (wrap),
    .clk_mon_o (clk_mon_o)
  );

  msk_dd_detector #(.BIT_CYC(BIT_CYC)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .wrap_i (wrap),
    .s_i    (s),
    .taps_i (chain[NUM_TAPS:1]),
    .det_o  (det)
  );

  msk_dd_corrector u_cor (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wrap_i (wrap),
    .det_i  (det),
    .bit_o  (corr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q  <= 1'b0;
      data_q <= 1'b0;
      mon_q  <= 1'b0;
    end else if (!en) begin
      stb_q  <= 1'b0;
      data_q <= 1'b0;
    end else begin
      stb_q  <= wrap;
      data_q <= wrap & corr;
      if (wrap) mon_q <= corr;
    end
  end

  assign data_o     = data_q;
  assign bit_stb_o  = stb_q;
  assign data_mon_o = mon_q;

  p_no_stb_standby_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> !bit_stb_o);

  p_mon_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_mon_o) |-> bit_stb_o);
endmodule

// File: tb/msk_dd_demod_tb_top.sv
module msk_dd_demod_tb_top;
  localparam int N      = 450;
  localparam int NBITS  = 40;
  localparam int GL_BIT = 20;
  localparam int SB_BIT = 30;

  logic clk = 1'b0, rst_ni = 1'b0, standby_i = 1'b0, msk_i = 1'b0;
  logic data_o, bit_stb_o, data_mon_o, clk_mon_o;

  int n_tests = 0, n_fail = 0, cyc = 0, last_stb = 0, m = 0;
  bit sb_on = 1'b0;
  bit exp_q[$];
  bit lv[NBITS];

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  msk_dd_demod #(.BIT_CYC(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .standby_i(standby_i), .msk_i(msk_i),
    .data_o(data_o), .bit_stb_o(bit_stb_o), .data_mon_o(data_mon_o), .clk_mon_o(clk_mon_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic wait_stb(output int gap);
    do @(negedge clk); while (!bit_stb_o);
    gap = cyc - last_stb;
    last_stb = cyc;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (sb_on && bit_stb_o && exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      if (m - 1 == GL_BIT + 1)
        chk(data_o == e, "R5 corrected bit", data_o, e);
      else if (m - 1 == GL_BIT || m - 1 == GL_BIT + 2)
        chk(data_o == e, "R4 minority disturbance", data_o, e);
      else if (m - 1 >= SB_BIT)
        chk(data_o == e, "R7 R9 stream after standby", data_o, e);
      else
        chk(data_o == e, "R3 stream bit", data_o, e);
      chk(data_mon_o == data_o, "R8 data monitor", data_mon_o, data_o);
      m++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    finish_run();
  end

  task automatic do_standby();
    int seen = 0;
    logic mon0;
    @(negedge clk);
    standby_i = 1'b1;
    mon0 = data_mon_o;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (bit_stb_o) seen++;
      if (i == 50 || i == 200) msk_i = ~msk_i;
    end
    chk(seen == 0, "R7 no strobe in standby", seen, 0);
    chk(data_mon_o == mon0, "R7 monitor frozen", data_mon_o, mon0);
    standby_i = 1'b0;
  endtask

  initial begin
    int g;
    logic [7:0] r;
    repeat (5) @(negedge clk);
    chk(data_o == 1'b0, "R1 data_o reset", data_o, 0);
    chk(bit_stb_o == 1'b0, "R1 strobe reset", bit_stb_o, 0);
    chk(data_mon_o == 1'b0, "R1 monitor reset", data_mon_o, 0);
    chk(clk_mon_o == 1'b1, "R1 clock monitor reset", clk_mon_o, 1);
    rst_ni = 1'b1;

    // free run with held input
    wait_stb(g);
    wait_stb(g);
    chk(g == N, "R2 free-run period", g, N);
    chk(clk_mon_o == 1'b1, "R8 clk_mon after wrap", clk_mon_o, 1);
    repeat (100) @(negedge clk);
    chk(clk_mon_o == 1'b1, "R8 clk_mon first half", clk_mon_o, 1);
    chk(data_o == 1'b0, "R3 data low between strobes", data_o, 0);
    repeat (200) @(negedge clk);
    chk(clk_mon_o == 1'b0, "R8 clk_mon second half", clk_mon_o, 0);
    wait_stb(g);
    chk(g == N, "R2 period again", g, N);

    // phase nudges
    repeat (50) @(negedge clk);
    msk_i = 1'b1;
    wait_stb(g);
    chk(g == N + 1, "R6 early-half edge stretches", g, N + 1);
    wait_stb(g);
    chk(g == N + 1, "R6 delayed-copy edge stretches", g, N + 1);
    wait_stb(g);
    chk(g == N, "R2 quiet window", g, N);
    repeat (400) @(negedge clk);
    msk_i = 1'b0;
    wait_stb(g);
    chk(g == N - 1, "R6 late-half edge shortens", g, N - 1);

    // stream test from a fresh reset
    @(negedge clk);
    rst_ni = 1'b0;
    msk_i  = 1'b0;
    repeat (5) @(negedge clk);
    r = 8'hA5;
    for (int k = 0; k < NBITS; k++) begin
      lv[k] = r[0];
      r = {r[6:0], r[7] ^ r[5] ^ r[4] ^ r[3]};
    end
    exp_q.push_back(1'b0);
    for (int k = 0; k < NBITS; k++)
      exp_q.push_back(lv[k] ^ ((k > 0) ? lv[k-1] : 1'b0));
    m = 0;
    sb_on = 1'b1;
    rst_ni = 1'b1;
    for (int k = 0; k < NBITS; k++) begin
      for (int j = 0; j < N; j++) begin
        bit inv;
        if (k == SB_BIT && j == 100) do_standby();
        inv = (k == GL_BIT && j >= 250) || (k == GL_BIT + 1 && j < 70);
        @(negedge clk);
        msk_i = lv[k] ^ inv;
      end
    end
    repeat (3 * N) @(negedge clk);
    sb_on = 1'b0;
    chk(exp_q.size() == 0, "R3 all bits delivered", exp_q.size(), 0);
    chk(m == NBITS + 1, "R7 strobe count across standby", m, NBITS + 1);
    finish_run();
  end
endmodule